// File: doc/BRIEF.md
# Character Display Register File

This block is the write-only register file behind an eight-character dot-matrix display. A host processor drives an asynchronous, level-sensitive parallel bus: an active-low chip select, an active-low write strobe, an active-low line that picks the per-character flash bits, a 4-bit address and an 8-bit data byte. The block samples these lines into the system clock domain. It turns each strobe into one register write and holds three kinds of state. The first is eight character words, each a 7-bit character code plus a font page bit. The second is eight per-character flash flags. The third is one 8-bit attribute control word. All stored state is presented in parallel to the scan and drive logic that follows.

A control word with its top bit set starts a timed blanking sequence. It fills every character word with the space code 20h and clears all flash flags. For a programmable number of clock cycles (3 ms at the intended clock) it then refuses character and flash writes, and it flags this on `busy`. Writing a control word with the top bit low ends the sequence early. The bus carries no data stream with back-pressure, so no valid/ready handshake appears here. The host must respect `busy` or the bus timing instead.

Top module: `dispreg_top`

## Requirements
- R1: A write is committed exactly once per falling edge of `bus_wr_n` that is seen while `bus_cs_n` is low. A strobe with `bus_cs_n` high changes nothing. The result is visible on the outputs no more than four clock cycles after the strobe falls.
- R2: With `bus_flash_n` high and `bus_addr[3]`=1, the full data byte goes into character word `bus_addr[2:0]`, which appears at `disp_mem[8*i +: 8]`. Bits 6..0 are the code and bit 7 is the font page select.
- R3: With `bus_flash_n` high and `bus_addr[3]`=0, the data byte goes into `ctrl_word`. Address bits 2..0 are ignored.
- R4: With `bus_flash_n` low, data bit 0 becomes flash flag `flash_flags[bus_addr[2:0]]`. Data bits 7..1 and `bus_addr[3]` are ignored, and the control word is not touched.
- R5: While `rst_n` is low, and right after it rises, `ctrl_word` and `flash_flags` are 0, every character word is 20h and `busy` is low.
- R6: A control word write with bit 7 set makes all character words 20h and all flash flags 0. It stores the written byte in `ctrl_word` and raises `busy` on the next cycle.
- R7: Without further control writes, `busy` stays high for exactly `CLEAR_CYCLES` clock cycles and then falls.
- R8: A control word write with bit 7 clear, made while `busy` is high, drops `busy` on the next cycle. Character writes take effect again after that.
- R9: While `busy` is high, character writes and flash writes have no effect. Control word writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the display reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_flash_n | input | 1 | Low selects the flash flag array |
| bus_addr | input | 4 | Bit 3 picks character (1) or control (0), bits 2..0 the character |
| bus_data | input | 8 | Write data |
| disp_mem | output | 64 | Character words, word i at bits 8i+7..8i |
| flash_flags | output | 8 | Per-character flash flags |
| ctrl_word | output | 8 | Attribute control word |
| busy | output | 1 | High while the blanking sequence runs |

## Verification
The bench holds a strobe low for several cycles. A design that committed on the level instead of the edge would still show one value here, so the single-commit property is watched by an assertion. A flash write with only bit 0 cleared and the other bits set must clear the flag and leave the control word alone. A decoder that looked at address bit 3 or the wrong data bit would set the flag or corrupt the control word. Character and flash writes issued during the blanking window must leave all words at 20h, which catches a design that gates only one of them. The blanking window is measured in cycles and then cut short by a control write with bit 7 clear. An off-by-one counter, or a cancel that fails to release `busy`, shows up as a wrong count or a lost character write.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;
  localparam logic [7:0] BLANK_CODE = 8'h20;

  typedef struct packed {
    logic       flash_n;
    logic [3:0] addr;
    logic [7:0] data;
  } bus_word_t;
endpackage

// File: rtl/dispreg_bus_sync.sv
module dispreg_bus_sync
  import dispreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n,
  input  logic      wr_n,
  input  bus_word_t bus_in,
  output logic      commit,
  output bus_word_t bus_out
);
  logic      cs_s1, cs_s2;
  logic      wr_s1, wr_s2, wr_s3;
  bus_word_t bw_s1, bw_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s1 <= 1'b1; cs_s2 <= 1'b1;
      wr_s1 <= 1'b1; wr_s2 <= 1'b1; wr_s3 <= 1'b1;
      bw_s1 <= '0;   bw_s2 <= '0;
    end else begin
      cs_s1 <= cs_n;  cs_s2 <= cs_s1;
      wr_s1 <= wr_n;  wr_s2 <= wr_s1; wr_s3 <= wr_s2;
      bw_s1 <= bus_in; bw_s2 <= bw_s1;
    end
  end

  // falling edge of the synchronised strobe, qualified by chip select
  assign commit  = wr_s3 && !wr_s2 && !cs_s2;
  assign bus_out = bw_s2;

  // R1: a strobe yields a single commit pulse
  p_single_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/dispreg_decode.sv
module dispreg_decode
  import dispreg_pkg::*;
(
  input  logic      commit,
  input  bus_word_t bw,
  output logic      wr_char,
  output logic      wr_flash,
  output logic      wr_ctrl,
  output logic      clr_start,
  output logic      clr_stop
);
  always_comb begin
    wr_flash  = commit && !bw.flash_n;
    wr_char   = commit &&  bw.flash_n &&  bw.addr[3];
    wr_ctrl   = commit &&  bw.flash_n && !bw.addr[3];
    clr_start = wr_ctrl &&  bw.data[7];
    clr_stop  = wr_ctrl && !bw.data[7];
  end
endmodule

// File: rtl/dispreg_clear_timer.sv
module dispreg_clear_timer #(
  parameter int CLEAR_CYCLES = 150000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic busy
);
  localparam int CW = $clog2(CLEAR_CYCLES + 1);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CLEAR_CYCLES - 1);
    end else if (stop) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;

  // R6: a clear start raises busy
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R7/R8: busy only drops on count expiry or an explicit stop
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt_q == '0 || stop));
endmodule

// File: rtl/dispreg_store.sv
module dispreg_store
  import dispreg_pkg::*;
#(
  parameter int NUM_CHARS = 8,
  parameter int DATA_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_char,
  input  logic                        wr_flash,
  input  logic                        wr_ctrl,
  input  logic                        clr_start,
  input  logic                        busy,
  input  logic [$clog2(NUM_CHARS)-1:0] sel,
  input  logic [DATA_W-1:0]           data,
  output logic [NUM_CHARS*DATA_W-1:0] mem_flat,
  output logic [NUM_CHARS-1:0]        flash_q,
  output logic [DATA_W-1:0]           ctrl_q
);
  localparam int IDX_W = $clog2(NUM_CHARS);

  logic char_en, flash_en;
  assign char_en  = wr_char  && !busy;
  assign flash_en = wr_flash && !busy;

  for (genvar g = 0; g < NUM_CHARS; g++) begin : g_char
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                word_q <= DATA_W'(BLANK_CODE);
      else if (clr_start)                        word_q <= DATA_W'(BLANK_CODE);
      else if (char_en && sel == IDX_W'(g))      word_q <= data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                flash_q[g] <= 1'b0;
      else if (clr_start)                        flash_q[g] <= 1'b0;
      else if (flash_en && sel == IDX_W'(g))     flash_q[g] <= data[0];
    end
    assign mem_flat[g*DATA_W +: DATA_W] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= data;
  end

  // R9: character memory frozen while busy
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_flat));
  // R6: clear start blanks memory and flags
  p_clear_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_start |=> (mem_flat == {NUM_CHARS{DATA_W'(BLANK_CODE)}} && flash_q == '0));
  // R4: flash writes leave the control word alone
  p_flash_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flash |=> $stable(ctrl_q));
endmodule

// File: rtl/dispreg_top.sv
module dispreg_top
  import dispreg_pkg::*;
#(
  parameter int CLEAR_CYCLES = 150000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs_n,
  input  logic        bus_wr_n,
  input  logic        bus_flash_n,
  input  logic [3:0]  bus_addr,
  input  logic [7:0]  bus_data,
  output logic [63:0] disp_mem,
  output logic [7:0]  flash_flags,
  output logic [7:0]  ctrl_word,
  output logic        busy
);
  localparam int NUM_CHARS = 8;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = $clog2(NUM_CHARS);

  bus_word_t bw_in, bw;
  logic commit, wr_char, wr_flash, wr_ctrl, clr_start, clr_stop;

  assign bw_in = '{flash_n: bus_flash_n, addr: bus_addr, data: bus_data};

  dispreg_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .wr_n(bus_wr_n),
    .bus_in(bw_in), .commit(commit), .bus_out(bw)
  );

  dispreg_decode u_dec (
    .commit(commit), .bw(bw), .wr_char(wr_char), .wr_flash(wr_flash),
    .wr_ctrl(wr_ctrl), .clr_start(clr_start), .clr_stop(clr_stop)
  );

  dispreg_clear_timer #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(clr_start), .stop(clr_stop), .busy(busy)
  );

  dispreg_store #(.NUM_CHARS(NUM_CHARS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_char(wr_char), .wr_flash(wr_flash),
    .wr_ctrl(wr_ctrl), .clr_start(clr_start), .busy(busy),
    .sel(bw.addr[IDX_W-1:0]), .data(bw.data),
    .mem_flat(disp_mem), .flash_q(flash_flags), .ctrl_q(ctrl_word)
  );
endmodule

// File: tb/dispreg_top_tb_top.sv
module dispreg_top_tb_top;
  localparam int CLR = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, fl_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  data = '0;
  logic [63:0] mem;
  logic [7:0]  flags, ctrl;
  logic        busy;
  int checks = 0, errors = 0, busy_cycles = 0;

  always #10 clk = ~clk;

  dispreg_top #(.CLEAR_CYCLES(CLR)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n),
    .bus_flash_n(fl_n), .bus_addr(addr), .bus_data(data),
    .disp_mem(mem), .flash_flags(flags), .ctrl_word(ctrl), .busy(busy)
  );

  always @(negedge clk) if (busy) busy_cycles++;

  // vector: flash_n, addr, data, sel(0 char@addr,1 ctrl,2 flags), expected, req
  localparam logic [26:0] VEC [10] = '{
    {1'b1, 4'h8, 8'h41, 2'd0, 8'h41, 4'd2},  // R2 char 0
    {1'b1, 4'hF, 8'hC5, 2'd0, 8'hC5, 4'd2},  // R2 char 7, page bit
    {1'b1, 4'hB, 8'h7A, 2'd0, 8'h7A, 4'd2},  // R2 char 3
    {1'b1, 4'h0, 8'h13, 2'd1, 8'h13, 4'd3},  // R3 control
    {1'b1, 4'h5, 8'h4C, 2'd1, 8'h4C, 4'd3},  // R3 low addr bits ignored
    {1'b0, 4'h3, 8'hFF, 2'd2, 8'h08, 4'd4},  // R4 flag 3 set
    {1'b0, 4'hE, 8'h01, 2'd2, 8'h48, 4'd4},  // R4 addr bit 3 ignored
    {1'b0, 4'h3, 8'hFE, 2'd2, 8'h40, 4'd4},  // R4 only bit 0 used
    {1'b0, 4'h0, 8'h00, 2'd1, 8'h4C, 4'd4},  // R4 control untouched
    {1'b1, 4'hB, 8'h3D, 2'd0, 8'h3D, 4'd2}   // R2 overwrite char 3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic f, input logic [3:0] a, input logic [7:0] d,
                           input logic cs = 1'b0);
    @(negedge clk);
    fl_n = f; addr = a; data = d; cs_n = cs;
    @(negedge clk);
    wr_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    check("R5 ctrl in reset", ctrl, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: state right after reset
    check("R5 ctrl", ctrl, 8'h00);
    check("R5 flags", flags, 8'h00);
    check("R5 busy", {7'd0, busy}, 8'h00);
    for (int i = 0; i < 8; i++) check("R5 char blank", mem[8*i +: 8], 8'h20);

    for (int v = 0; v < 10; v++) begin
      bus_write(VEC[v][26], VEC[v][25:22], VEC[v][21:14]);
      case (VEC[v][13:12])
        2'd0:    got = mem[8*VEC[v][24:22] +: 8];
        2'd1:    got = ctrl;
        default: got = flags;
      endcase
      check($sformatf("R%0d vector %0d", VEC[v][3:0], v), got, VEC[v][11:4]);
    end

    // R1: chip select high blocks the write
    bus_write(1'b1, 4'h8, 8'h99, 1'b1);
    check("R1 cs high ignored", mem[7:0], 8'h41);

    // R6: clear start
    busy_cycles = 0;
    bus_write(1'b1, 4'h0, 8'h85);
    check("R6 busy high", {7'd0, busy}, 8'h01);
    check("R6 ctrl stored", ctrl, 8'h85);
    check("R6 flags cleared", flags, 8'h00);
    for (int i = 0; i < 8; i++) check("R6 char blank", mem[8*i +: 8], 8'h20);
    // R9: writes during busy are dropped
    bus_write(1'b1, 4'hA, 8'h33);
    bus_write(1'b0, 4'h1, 8'h01);
    check("R9 char ignored", mem[23:16], 8'h20);
    check("R9 flash ignored", flags, 8'h00);
    // R7: measure window
    while (busy) @(negedge clk);
    check("R7 busy length", 8'(busy_cycles), 8'(CLR));
    bus_write(1'b1, 4'hA, 8'h33);
    check("R7 writes resume", mem[23:16], 8'h33);

    // R8: early cancel
    bus_write(1'b1, 4'h0, 8'hC0);
    check("R8 busy set", {7'd0, busy}, 8'h01);
    bus_write(1'b1, 4'h0, 8'h03);
    check("R8 busy dropped", {7'd0, busy}, 8'h00);
    check("R8 ctrl", ctrl, 8'h03);
    bus_write(1'b1, 4'hC, 8'h5A);
    check("R8 char accepted", mem[39:32], 8'h5A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule